// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Neuron Group

This block holds eight digital integrate-and-fire neurons that share one firing threshold. Each neuron receives a one-cycle event pulse from its own oscillator, already synchronized to the system clock. On every event the neuron's 8-bit membrane counter advances by one. When the counter plus the incoming event reaches the threshold, the neuron fires. A firing neuron emits a one-cycle spike, returns its counter to zero and adds one to a saturating 16-bit spike tally.

Two optional mechanisms sharpen the contrast between neurons. The first is leak. A programmable 16-bit timer periodically knocks the least significant bit off every counter, which lowers all firing rates evenly. The second is lateral inhibition. Whenever any neuron fires, a programmable bit mask is cleared in the counters of the neurons that did not fire. A neuron that fires often therefore holds back its slower neighbours more than they hold it back. With both mechanisms off, every neuron is a plain count-to-threshold unit.

Top module: `lif_group`

## Requirements
- R1: While `rst` is high and after it falls, every membrane counter, every spike output and every spike tally reads zero.
- R2: With leak and inhibition off, each event pulse on `evt_i[i]` raises neuron i's counter by exactly one, and a cycle without an event leaves the counter unchanged.
- R3: Neuron i fires in a cycle where its counter plus that cycle's event bit is greater than or equal to `thresh_i`. `spike_o[i]` is then high for the following cycle only, and the counter restarts from zero. A neuron with threshold T therefore spikes on its T-th event after reset.
- R4: With `leak_en_i` high and period P, bit 0 of every non-firing counter is cleared on every P-th clock edge after leak is enabled. A P of 0 behaves as 1. The clear is applied after that cycle's increment.
- R5: With `leak_en_i` low, no counter bit is ever cleared by the leak timer.
- R6: With `inhib_en_i` high, a spike from any neuron clears the bits set in `inhib_mask_i` (bit k clears counter bit k) in the counter of every neuron that does not fire in the same cycle.
- R7: With `inhib_en_i` low, a spike has no effect on the other neurons' counters.
- R8: When several neurons reach threshold in the same cycle, all of them spike and all of them restart from zero.
- R9: Each spike adds one to that neuron's 16-bit tally at `spike_cnt_o[16*i+15:16*i]`, which sticks at 65535 instead of wrapping.
- R10: A high `cnt_clr_i` zeroes all spike tallies on the next edge and takes priority over a spike in the same cycle.
- R11: The threshold is shared, so the same setting governs every neuron of the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Per-neuron oscillator event pulses |
| thresh_i | input | 8 | Shared firing threshold |
| leak_en_i | input | 1 | Enables periodic LSB clearing |
| leak_period_i | input | 16 | Leak interval in clock cycles |
| inhib_en_i | input | 1 | Enables lateral inhibition |
| inhib_mask_i | input | 8 | Counter bits cleared in non-firing neurons on a spike |
| cnt_clr_i | input | 1 | Clears all spike tallies |
| spike_o | output | 8 | One-cycle spike pulses |
| spike_cnt_o | output | 128 | Saturating spike tallies, 16 bits per neuron |

## Verification
The membrane counters cannot be seen at the ports. A wrong counter value therefore shows up only as a spike that arrives early or late, measured in events from a known starting point. The bench drives a known number of events and records the exact event on which each spike appears. A stray leak or inhibition clear, or a missing one, then moves that spike by a predictable number of events. Errors in the tallies show within one cycle of a spike, or at the 65535 boundary.

// File: rtl/lif_pkg.sv
package lif_pkg;
    localparam int NEUR_DEF   = 8;
    localparam int MEM_W_DEF  = 8;
    localparam int TALLY_W_DEF = 16;
    localparam int PER_W_DEF  = 16;

    // clearing actions applied to one membrane counter in a cycle
    typedef struct packed {
        logic lsb_leak;
        logic inhibit;
    } clr_ctl_t;
endpackage

// File: rtl/lif_leak_timer.sv
module lif_leak_timer #(
    parameter int PER_W = lif_pkg::PER_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    logic [PER_W-1:0] t_q;
    logic [PER_W-1:0] last;

    always_comb begin
        last = (period == '0) ? '0 : period - 1'b1;
        tick = en && (t_q >= last);
    end

    always_ff @(posedge clk) begin
        if (rst || !en || tick) t_q <= '0;
        else                    t_q <= t_q + 1'b1;
    end

    p_tick_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
        tick |-> en);
    p_tick_restarts_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && en && period > 1) |=> !tick);
endmodule

// File: rtl/lif_neuron.sv
module lif_neuron
    import lif_pkg::*;
#(
    parameter int MEM_W   = MEM_W_DEF,
    parameter int TALLY_W = TALLY_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt,
    input  logic [MEM_W-1:0]   thresh,
    input  clr_ctl_t           ctl,
    input  logic [MEM_W-1:0]   mask,
    input  logic               tally_clr,
    output logic               fire_c,
    output logic               spike_o,
    output logic [TALLY_W-1:0] tally_o
);
    localparam logic [TALLY_W-1:0] TALLY_MAX = '1;

    logic [MEM_W-1:0] mem_q;
    logic [MEM_W-1:0] mem_d;
    logic [MEM_W:0]   sum;

    always_comb begin
        sum    = {1'b0, mem_q} + {{MEM_W{1'b0}}, evt};
        fire_c = sum >= {1'b0, thresh};
        mem_d  = sum[MEM_W-1:0];
        if (ctl.lsb_leak) mem_d[0] = 1'b0;
        if (ctl.inhibit)  mem_d    = mem_d & ~mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q   <= '0;
            spike_o <= 1'b0;
            tally_o <= '0;
        end else begin
            mem_q   <= fire_c ? '0 : mem_d;
            spike_o <= fire_c;
            if (tally_clr)                          tally_o <= '0;
            else if (fire_c && tally_o != TALLY_MAX) tally_o <= tally_o + 1'b1;
        end
    end

    p_fire_restart_r3: assert property (@(posedge clk) disable iff (rst)
        fire_c |=> (spike_o && mem_q == '0));
    p_leak_lsb_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl.lsb_leak && !fire_c) |=> !mem_q[0]);
    p_inhib_bits_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl.inhibit && !fire_c) |=> ((mem_q & $past(mask)) == '0));
    p_tally_sticks_r9: assert property (@(posedge clk) disable iff (rst)
        (tally_o == TALLY_MAX && !tally_clr) |=> tally_o == TALLY_MAX);
    p_tally_clear_r10: assert property (@(posedge clk) disable iff (rst)
        tally_clr |=> tally_o == '0);
    p_quiet_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!evt && !fire_c && !ctl.lsb_leak && !ctl.inhibit) |=> $stable(mem_q));
endmodule

// File: rtl/lif_group.sv
module lif_group
    import lif_pkg::*;
#(
    parameter int NEUR    = NEUR_DEF,
    parameter int MEM_W   = MEM_W_DEF,
    parameter int TALLY_W = TALLY_W_DEF,
    parameter int PER_W   = PER_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NEUR-1:0]         evt_i,
    input  logic [MEM_W-1:0]        thresh_i,
    input  logic                    leak_en_i,
    input  logic [PER_W-1:0]        leak_period_i,
    input  logic                    inhib_en_i,
    input  logic [MEM_W-1:0]        inhib_mask_i,
    input  logic                    cnt_clr_i,
    output logic [NEUR-1:0]         spike_o,
    output logic [NEUR*TALLY_W-1:0] spike_cnt_o
);
    logic            leak_tick;
    logic [NEUR-1:0] fire_v;
    logic            any_fire;

    lif_leak_timer #(.PER_W(PER_W)) u_leak (
        .clk    (clk),
        .rst    (rst),
        .en     (leak_en_i),
        .period (leak_period_i),
        .tick   (leak_tick)
    );

    // a firing neuron restarts from zero, so the group-wide fire flag suffices
    assign any_fire = |fire_v;

    for (genvar g = 0; g < NEUR; g++) begin : g_neur
        clr_ctl_t ctl;
        assign ctl.lsb_leak = leak_tick;
        assign ctl.inhibit  = inhib_en_i && any_fire;

        lif_neuron #(.MEM_W(MEM_W), .TALLY_W(TALLY_W)) u_neur (
            .clk       (clk),
            .rst       (rst),
            .evt       (evt_i[g]),
            .thresh    (thresh_i),
            .ctl       (ctl),
            .mask      (inhib_mask_i),
            .tally_clr (cnt_clr_i),
            .fire_c    (fire_v[g]),
            .spike_o   (spike_o[g]),
            .tally_o   (spike_cnt_o[g*TALLY_W +: TALLY_W])
        );
    end

    p_spikes_follow_fire_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> spike_o == $past(fire_v));
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (spike_o == '0 && spike_cnt_o == '0));
endmodule

// File: tb/lif_group_tb.sv
module lif_group_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic [7:0]   evt_i;
    logic [7:0]   thresh_i;
    logic         leak_en_i;
    logic [15:0]  leak_period_i;
    logic         inhib_en_i;
    logic [7:0]   inhib_mask_i;
    logic         cnt_clr_i;
    logic [7:0]   spike_o;
    logic [127:0] spike_cnt_o;

    int total = 0;
    int bad   = 0;
    logic [7:0] seen;

    localparam logic [7:0] TH_V [0:5] = '{8'd1, 8'd2, 8'd16, 8'd37, 8'd200, 8'd255};
    localparam int         NR_V [0:5] = '{0, 3, 5, 7, 2, 6};

    always #5 clk = ~clk;

    lif_group u_dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .thresh_i(thresh_i),
        .leak_en_i(leak_en_i), .leak_period_i(leak_period_i),
        .inhib_en_i(inhib_en_i), .inhib_mask_i(inhib_mask_i),
        .cnt_clr_i(cnt_clr_i), .spike_o(spike_o), .spike_cnt_o(spike_cnt_o)
    );

    function automatic logic [15:0] tally(input int i);
        return spike_cnt_o[16*i +: 16];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // n event cycles on the neurons in m; seen collects every spike observed
    task automatic pulse(input logic [7:0] m, input int n);
        seen = '0;
        for (int k = 0; k < n; k++) begin
            evt_i = m;
            step();
            seen |= spike_o;
        end
        evt_i = '0;
    endtask

    task automatic do_reset(input logic [7:0] th);
        rst = 1'b1; evt_i = '0; thresh_i = th; leak_en_i = 1'b0;
        leak_period_i = '0; inhib_en_i = 1'b0; inhib_mask_i = '0; cnt_clr_i = 1'b0;
        step(); step();
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset(8'd4);
        chk(spike_o == '0, "R1 spikes", int'(spike_o), 0);
        chk(spike_cnt_o == '0, "R1 tallies", int'(spike_cnt_o[31:0]), 0);

        // R2 R3 table: threshold T fires exactly on the T-th event
        for (int v = 0; v < 6; v++) begin
            do_reset(TH_V[v]);
            pulse(8'(1 << NR_V[v]), int'(TH_V[v]) - 1);
            chk(seen == '0, "R2 early spike", int'(seen), 0);
            step(); // quiet cycle: count must hold
            pulse(8'(1 << NR_V[v]), 1);
            chk(spike_o == 8'(1 << NR_V[v]), "R3 spike at threshold", int'(spike_o), 1 << NR_V[v]);
            chk(tally(NR_V[v]) == 16'd1, "R9 tally one", int'(tally(NR_V[v])), 1);
            step();
            chk(spike_o == '0, "R3 single pulse", int'(spike_o), 0);
        end

        // R11 shared threshold: all neurons, same setting, same event count
        do_reset(8'd5);
        pulse(8'hFF, 4);
        chk(seen == '0, "R11 no early", int'(seen), 0);
        pulse(8'hFF, 1);
        chk(spike_o == 8'hFF, "R11 R8 all fire", int'(spike_o), 255);

        // R3 restart from zero after spike
        pulse(8'h01, 4);
        chk(seen == '0, "R3 restart", int'(seen), 0);

        // R4 leak period 1 clears after increment: count never grows
        do_reset(8'd2);
        leak_en_i = 1'b1; leak_period_i = 16'd1;
        pulse(8'h10, 10);
        chk(seen == '0, "R4 period1 leak", int'(seen), 0);
        leak_period_i = 16'd0;
        pulse(8'h10, 6);
        chk(seen == '0, "R4 period0 leak", int'(seen), 0);

        // R4 period 4: value survives edges 2 and 3
        do_reset(8'd2);
        leak_en_i = 1'b1; leak_period_i = 16'd4;
        pulse(8'h02, 1); step();
        pulse(8'h02, 1);
        chk(spike_o == 8'h02, "R4 no clear before tick", int'(spike_o), 2);

        // R4 period 4: 4th edge clears the LSB
        do_reset(8'd2);
        leak_en_i = 1'b1; leak_period_i = 16'd4;
        pulse(8'h02, 1); step(); step(); step();
        leak_en_i = 1'b0;
        pulse(8'h02, 1);
        chk(spike_o == '0, "R4 cleared at tick", int'(spike_o), 0);
        pulse(8'h02, 1);
        chk(spike_o == 8'h02, "R4 refill", int'(spike_o), 2);

        // R5 leak off: long idle keeps the count
        do_reset(8'd2);
        leak_period_i = 16'd1;
        pulse(8'h04, 1);
        repeat (20) step();
        pulse(8'h04, 1);
        chk(spike_o == 8'h04, "R5 no leak", int'(spike_o), 4);

        // R6 inhibition: mask bit 2 wipes a count of 4 in the neighbours
        do_reset(8'd8);
        inhib_en_i = 1'b1; inhib_mask_i = 8'h04;
        pulse(8'hFE, 4);
        pulse(8'h01, 7);
        pulse(8'h01, 1);
        chk(spike_o == 8'h01, "R6 firing neuron", int'(spike_o), 1);
        pulse(8'h02, 7);
        chk(seen == '0, "R6 neighbour cleared", int'(seen), 0);
        pulse(8'h02, 1);
        chk(spike_o == 8'h02, "R6 neighbour refires", int'(spike_o), 2);

        // R7 inhibition off: neighbour keeps its count
        do_reset(8'd8);
        inhib_mask_i = 8'h04;
        pulse(8'hFE, 4);
        pulse(8'h01, 8);
        pulse(8'h02, 3);
        chk(seen == '0, "R7 no early", int'(seen), 0);
        pulse(8'h02, 1);
        chk(spike_o == 8'h02, "R7 unaffected", int'(spike_o), 2);

        // R8 simultaneous spikes: both reset, bystander cleared
        do_reset(8'd8);
        inhib_en_i = 1'b1; inhib_mask_i = 8'h04;
        pulse(8'h03, 7);
        pulse(8'h04, 4);
        pulse(8'h03, 1);
        chk(spike_o == 8'h03, "R8 two fire", int'(spike_o), 3);
        pulse(8'h07, 7);
        chk(seen == '0, "R8 all restarted", int'(seen), 0);
        pulse(8'h07, 1);
        chk(spike_o == 8'h07, "R8 refire together", int'(spike_o), 7);

        // R9 saturation and R10 clear priority
        do_reset(8'd1);
        pulse(8'h08, 65540);
        chk(tally(3) == 16'hFFFF, "R9 saturates", int'(tally(3)), 65535);
        cnt_clr_i = 1'b1;
        pulse(8'h08, 1);
        chk(tally(3) == 16'd0, "R10 clear wins", int'(tally(3)), 0);
        cnt_clr_i = 1'b0;
        pulse(8'h08, 1);
        chk(tally(3) == 16'd1, "R10 count resumes", int'(tally(3)), 1);
        chk(tally(2) == 16'd0, "R9 other tally", int'(tally(2)), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule